// File: doc/BRIEF.md
# Six-Channel Sampling Converter Serial Readout and Power Sequencer

This block is the digital side of a six-channel simultaneous-sampling converter. It is modelled on the device side. A host issues a convert strobe and a serial clock. The block receives six parallel 14-bit raw conversion results. Each rising edge of the convert strobe captures all six results into a holding bank. The same edge moves the previous contents of the holding bank into a readout bank. The frame that follows therefore presents the results of the conversion before the one just started.

The readout frame is shifted on a single data line that has a separate drive enable, so it can be wired as a three-state pin. Each enabled channel takes sixteen serial clock rising edges: fourteen data bits first, most significant bit first, then two zero pad bits. A three-bit select code sets how many channels the frame carries. Code `n` gives channels 0 to `n`, and the codes at or above the channel count give all six. A mode input picks the word format. In unipolar mode the word is straight binary. In bipolar mode it is two's complement.

The block also tracks low-power states. It counts convert strobes that arrive while the serial clock stays idle. Two such strobes put it in the light low-power state. Four or more put it in the deep one. Any serial clock rising edge returns it to active. The convert strobe and the serial clock are level inputs sampled on the system clock `clk`, which must run fast enough to see every level of both.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo_oe` and `sdo` are 0, both power outputs are 0, and both sample banks hold zero.
- R2: The cycle after a rising edge of `conv` is seen, `sdo_oe` is 1. On that edge the holding bank is copied into the readout bank, and the holding bank takes the present `samples` value. The frame therefore carries the results captured by the previous strobe.
- R3: Channel 0 is sent first, in ascending channel order. Within a 16-edge slot, `sdo` first shows word bit 13 and then the lower bits in order down to bit 0, advancing on each `sck` rising edge. The last two positions of the slot are driven as 0. Channel `c` occupies `samples[14c+13:14c]`.
- R4: The frame carries `sel+1` slots for `sel` from 0 to 4 and six slots for `sel` 5, 6 and 7. `sel` is sampled at the strobe that opens the frame. `sdo_oe` falls on the `sck` rising edge that ends the last slot.
- R5: With `bip`=0 a word equals the raw sample. With `bip`=1 it equals raw minus 8192, taken modulo 2^14, which is two's complement. The mode used is the `bip` value at the strobe that captured that sample.
- R6: While `sdo_oe` is 0, `sdo` is 0, and `sck` edges change neither the line nor the frame state.
- R7: A `conv` rising edge in the middle of a frame aborts it. A new frame starts at bit 13 of channel 0 with the newly shifted bank.
- R8: One `conv` strobe with no `sck` edge since the last one leaves the power state unchanged. The second consecutive one sets `pwr_nap`, and the third keeps it.
- R9: The fourth and every later consecutive strobe sets `pwr_sleep` and clears `pwr_nap`. The two power outputs are never 1 together.
- R10: Any `sck` rising edge clears the strobe count and returns both power outputs to 0 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobe and serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv | input | 1 | Convert strobe; rising edge captures samples and opens a frame |
| sck | input | 1 | Serial clock; rising edge advances the frame |
| sel | input | 3 | Channel-count select |
| bip | input | 1 | 1 = bipolar (two's complement), 0 = unipolar (straight binary) |
| samples | input | 84 | Six raw 14-bit results, channel c at bits 14c+13:14c |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the data line |
| pwr_nap | output | 1 | Light low-power state |
| pwr_sleep | output | 1 | Deep low-power state |

## Verification
The bench sweeps all eight select codes against both modes. Each case is read out bit by bit over a full frame, which separates an off-by-one slot count and saturation errors at codes 5 to 7 from bit-order and pad errors. Sample sets alternate between all-ones/all-zeros extremes per channel and hashed words. The extremes expose a wrong sign-bit flip. The hashed words expose channel swaps and a missing one-frame delay. Further cases change the mode between the two strobes of a pair, abort a frame after 20 edges, and count a run of five idle strobes, so that mode-capture timing, restart and the nap/sleep thresholds are each told apart.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  // Output coding: bipolar flips the top bit of an offset-binary raw code.
  function automatic logic [31:0] fmt_code(input logic [31:0] raw,
                                           input int unsigned width,
                                           input logic bipolar);
    logic [31:0] top;
    top = 32'd1 << (width - 1);
    return bipolar ? (raw ^ top) : raw;
  endfunction

  // Slots in a frame: select code plus one, saturating at the channel count.
  function automatic int unsigned slots_for_sel(input int unsigned code,
                                                input int unsigned nch);
    return (code + 1 > nch) ? nch : code + 1;
  endfunction

  // Power state from the count of idle convert strobes.
  function automatic pwr_e pwr_from_count(input int unsigned cnt,
                                          input int unsigned nap_at,
                                          input int unsigned sleep_at);
    if (cnt >= sleep_at) return PWR_SLEEP;
    if (cnt >= nap_at)   return PWR_NAP;
    return PWR_ACTIVE;
  endfunction

endpackage

// File: rtl/adc_sample_bank.sv
module adc_sample_bank #(
  parameter int NCH = 6,
  parameter int DW  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_rise,
  input  logic              bip,
  input  logic [NCH*DW-1:0] samples_i,
  output logic [NCH*DW-1:0] shown_o
);
  import adc_sp_pkg::*;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] held_q;
    logic [DW-1:0] shown_q;
    logic [DW-1:0] fmt_w;

    assign fmt_w = DW'(fmt_code(32'(samples_i[ch*DW +: DW]), DW, bip));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q  <= '0;
        shown_q <= '0;
      end else if (conv_rise) begin
        held_q  <= fmt_w;
        shown_q <= held_q;
      end
    end

    assign shown_o[ch*DW +: DW] = shown_q;
  end

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int NCH       = 6,
  parameter int DW        = 14,
  parameter int SLOT_BITS = 16,
  parameter int SELW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_rise,
  input  logic              sck_rise,
  input  logic [SELW-1:0]   sel,
  input  logic [NCH*DW-1:0] shown_i,
  output logic              sdo_o,
  output logic              oe_o
);
  import adc_sp_pkg::*;

  localparam int SLW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NCW = $clog2(NCH + 1);
  localparam int BW  = $clog2(SLOT_BITS);

  logic           active_q;
  logic [SLW-1:0] slot_q;
  logic [BW-1:0]  bit_q;
  logic [NCW-1:0] nslots_q;

  logic           slot_end;
  logic           last_slot;
  logic [DW-1:0]  cur_word;
  logic [DW-1:0]  shifted;
  logic           in_data;

  assign slot_end  = (bit_q == BW'(SLOT_BITS - 1));
  assign last_slot = ((NCW'(slot_q) + NCW'(1)) == nslots_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      nslots_q <= '0;
    end else if (conv_rise) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      bit_q    <= '0;
      nslots_q <= NCW'(slots_for_sel(32'(sel), NCH));
    end else if (sck_rise && active_q) begin
      if (slot_end) begin
        bit_q <= '0;
        if (last_slot) active_q <= 1'b0;
        else           slot_q   <= slot_q + SLW'(1);
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  always_comb begin
    cur_word = '0;
    for (int c = 0; c < NCH; c++) begin
      if (32'(slot_q) == c) cur_word = shown_i[c*DW +: DW];
    end
  end

  assign shifted = cur_word << bit_q;
  assign in_data = (32'(bit_q) < DW);
  assign sdo_o   = active_q & in_data & shifted[DW-1];
  assign oe_o    = active_q;

endmodule

// File: rtl/adc_power_seq.sv
module adc_power_seq #(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_rise,
  input  logic             sck_rise,
  output adc_sp_pkg::pwr_e state_o
);
  import adc_sp_pkg::*;

  localparam int CW = $clog2(SLEEP_PULSES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  pwr_e          state_q;

  always_comb begin
    cnt_n = cnt_q;
    if (sck_rise) cnt_n = '0;
    if (conv_rise && cnt_n != CW'(SLEEP_PULSES)) cnt_n = cnt_n + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= PWR_ACTIVE;
    end else begin
      cnt_q   <= cnt_n;
      state_q <= pwr_from_count(32'(cnt_n), NAP_PULSES, SLEEP_PULSES);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int NCH          = 6,
  parameter int DW           = 14,
  parameter int SLOT_BITS    = 16,
  parameter int SELW         = 3,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv,
  input  logic              sck,
  input  logic [SELW-1:0]   sel,
  input  logic              bip,
  input  logic [NCH*DW-1:0] samples,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              pwr_nap,
  output logic              pwr_sleep
);
  import adc_sp_pkg::*;

  logic conv_q;
  logic sck_q;
  logic conv_rise;
  logic sck_rise;
  logic [NCH*DW-1:0] shown;
  pwr_e pwr_state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      conv_q <= conv;
      sck_q  <= sck;
    end
  end

  assign conv_rise = conv & ~conv_q;
  assign sck_rise  = sck & ~sck_q;

  adc_sample_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .bip(bip),
    .samples_i(samples), .shown_o(shown)
  );

  adc_frame_shifter #(.NCH(NCH), .DW(DW), .SLOT_BITS(SLOT_BITS), .SELW(SELW)) u_shift (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
    .sel(sel), .shown_i(shown), .sdo_o(sdo), .oe_o(sdo_oe)
  );

  adc_power_seq #(.NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
    .state_o(pwr_state)
  );

  assign pwr_nap   = (pwr_state == PWR_NAP);
  assign pwr_sleep = (pwr_state == PWR_SLEEP);

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_rise,
  input logic sck_rise,
  input logic oe,
  input logic sdo,
  input logic nap,
  input logic sleep
);

  a_r6_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !sdo);

  a_r2_frame_opens: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise |=> oe);

  a_r4_close_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(sck_rise));

  a_r8_nap_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nap) |-> $past(conv_rise));

  a_r9_sleep_after_nap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(nap));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nap && sleep));

  a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> (!nap && !sleep));

endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
  .oe(sdo_oe), .sdo(sdo), .nap(pwr_nap), .sleep(pwr_sleep)
);

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv = 1'b0;
  logic        sck = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic        bip = 1'b0;
  logic [83:0] samples = '0;
  logic        sdo, sdo_oe, pwr_nap, pwr_sleep;

  int total = 0;
  int bad = 0;

  logic [13:0] exp_w [6];
  logic [13:0] cur_w [6];

  always #10 clk = ~clk;

  adc_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .sel(sel), .bip(bip),
    .samples(samples), .sdo(sdo), .sdo_oe(sdo_oe),
    .pwr_nap(pwr_nap), .pwr_sleep(pwr_sleep)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [13:0] pat(input int k, input int ch);
    int h;
    if (k % 4 == 0) return (ch % 2 == 0) ? 14'h3FFF : 14'h0000;
    h = k * 7919 + ch * 3301 + 17;
    h = h ^ (h >> 3) ^ (k << 7);
    return 14'(h);
  endfunction

  task automatic load(input int k);
    for (int ch = 0; ch < 6; ch++) begin
      cur_w[ch] = pat(k, ch);
      samples[ch*14 +: 14] = cur_w[ch];
    end
  endtask

  // Expected word: bipolar is the raw code less mid-scale, wrapped to 14 bits.
  task automatic expect_from_cur(input logic b);
    for (int ch = 0; ch < 6; ch++)
      exp_w[ch] = b ? 14'(cur_w[ch] - 14'd8192) : cur_w[ch];
  endtask

  task automatic pulse_conv();
    @(negedge clk) conv = 1'b1;
    @(negedge clk) conv = 1'b0;
  endtask

  task automatic pulse_sck();
    @(negedge clk) sck = 1'b1;
    @(negedge clk) sck = 1'b0;
  endtask

  task automatic read_frame(input int nsl);
    for (int s = 0; s < nsl; s++) begin
      for (int b = 0; b < 16; b++) begin
        chk("R3 oe", 32'(sdo_oe), 32'd1);
        chk("R3 data", 32'(sdo), (b < 14) ? 32'(exp_w[s][13-b]) : 32'd0);
        pulse_sck();
      end
    end
    chk("R4 oe end", 32'(sdo_oe), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    chk("R1 sdo", 32'(sdo), 32'd0);
    chk("R1 nap", 32'(pwr_nap), 32'd0);
    chk("R1 sleep", 32'(pwr_sleep), 32'd0);

    // First frame after reset shows the cleared bank.
    sel = 3'd7;
    load(1);
    pulse_conv();
    chk("R2 oe", 32'(sdo_oe), 32'd1);
    for (int ch = 0; ch < 6; ch++) exp_w[ch] = 14'd0;
    read_frame(6);   // R1 zero bank
    pulse_sck();
    chk("R6 idle oe", 32'(sdo_oe), 32'd0);

    // Sweep every select code in both modes.
    for (int k = 0; k < 16; k++) begin
      sel = 3'(k % 8);
      bip = 1'(k / 8);
      load(2 * k + 4);
      expect_from_cur(bip);
      pulse_conv();
      chk("R8 single nap", 32'(pwr_nap), 32'd0);
      chk("R8 single sleep", 32'(pwr_sleep), 32'd0);
      load(2 * k + 5);
      pulse_conv();
      chk("R8 second nap", 32'(pwr_nap), 32'd1);
      read_frame((k % 8) > 4 ? 6 : (k % 8) + 1);   // R4 R5
      chk("R10 awake", 32'(pwr_nap), 32'd0);
      pulse_sck();
      chk("R6 idle oe", 32'(sdo_oe), 32'd0);
      chk("R6 idle sdo", 32'(sdo), 32'd0);
    end

    // R5: mode captured with the sample, not at the readout strobe.
    sel = 3'd5;
    bip = 1'b1;
    load(40);
    expect_from_cur(1'b1);
    pulse_conv();
    bip = 1'b0;
    load(41);
    pulse_conv();
    read_frame(6);

    // R7: abort mid-frame and restart on channel 0.
    sel = 3'd7;
    load(42);
    expect_from_cur(1'b0);
    pulse_conv();
    repeat (20) pulse_sck();
    chk("R7 mid oe", 32'(sdo_oe), 32'd1);
    load(43);
    pulse_conv();
    read_frame(6);

    // R9/R10: idle strobe thresholds.
    pulse_sck();
    pulse_conv();
    chk("R8 one nap", 32'(pwr_nap), 32'd0);
    pulse_conv();
    chk("R8 two nap", 32'(pwr_nap), 32'd1);
    pulse_conv();
    chk("R8 three nap", 32'(pwr_nap), 32'd1);
    chk("R9 three sleep", 32'(pwr_sleep), 32'd0);
    pulse_conv();
    chk("R9 four sleep", 32'(pwr_sleep), 32'd1);
    chk("R9 four nap", 32'(pwr_nap), 32'd0);
    pulse_conv();
    chk("R9 five sleep", 32'(pwr_sleep), 32'd1);
    pulse_sck();
    chk("R10 wake sleep", 32'(pwr_sleep), 32'd0);
    chk("R10 wake nap", 32'(pwr_nap), 32'd0);
    pulse_conv();
    chk("R10 count cleared", 32'(pwr_nap), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule